// File: doc/BRIEF.md
# Multi-channel frame alignment checker

Several converter channels each deliver one sample per fabric clock cycle, along with a frame clock whose period is two cycles. The two samples that arrive during one frame clock period form a pair. The channels are already sampled in lockstep. However, an individual channel may place its frame boundary one sample later than the others. It then pairs its samples one sample off, as (S1,S2),(S3,S4) where channel 0 gives (S0,S1),(S2,S3). Such a channel's frame clock is half a frame out of phase with channel 0.

This block finds frame starts on every channel and gives each channel an observation toggle that flips on every frame start. It compares each channel's frame-start cycles with those of channel 0, which is the reference, and raises a per-channel flag once they have agreed over a run of consecutive frames. It also raises a global flag when every channel agrees. Once per reference frame it presents a registered set of sample pairs with a valid strobe. When correction is enabled, a channel seen starting one cycle after the reference has its pair re-formed on the reference framing, built from its previous frame's second sample and its current frame's first sample. All channels leave with the same latency.

Top module: `frame_align_top`

## Requirements
- R1: A frame start on a channel is a cycle in which its frame clock is high and was low in the previous cycle. The previous level counts as low after reset or clear. Each channel's `toggle_o` bit flips in the cycle after every frame start of that channel.
- R2: `ch_aligned_o[0]` is always 1. For a channel c>0, `ch_aligned_o[c]` becomes 1 once MATCH_FRAMES (default 8) consecutive reference frame starts have each coincided with a frame start of channel c.
- R3: A cycle in which exactly one of channel 0 and channel c has a frame start is a mismatch. It restarts the run count of channel c, and `ch_aligned_o[c]` is 0 in the following cycle.
- R4: `all_aligned_o` is the AND of all per-channel flags. It is 0 in the cycle after any mismatch.
- R5: Let a reference frame start be cycle t. `pair_vld_o` is then high for exactly one cycle, cycle t+3. During that cycle, the 2*SW-bit field of channel c in `pair_o` (bits c*2*SW upward) holds the earlier sample in its low SW bits and the later sample in its high SW bits. For an uncorrected channel, the field holds the most recent pair of that channel's own framing whose second sample arrived by cycle t+1.
- R6: A channel c>0 is marked offset when its frame start falls one cycle after a reference frame start. The mark is removed when its frame start coincides with a reference frame start. While `realign_en_i` is 1 in cycle t+2 and the mark is set, the channel's field carries its samples from cycles t and t+1.
- R7: After reset, or in the cycle after `clr_i` is high, the toggles, run counts, offset marks, pairs and the strobe are all 0.
- R8: `pair_o` changes only in cycles where `pair_vld_o` is high, or after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock, one sample per channel per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of all state |
| realign_en_i | input | 1 | Enables re-pairing of offset channels |
| fclk_i | input | NCH | Frame clock level per channel |
| sample_i | input | NCH*SW | Current sample per channel, channel c at bits c*SW |
| toggle_o | output | NCH | Per-channel frame-start toggle |
| ch_aligned_o | output | NCH | Per-channel aligned flag |
| all_aligned_o | output | 1 | All channels aligned |
| pair_vld_o | output | 1 | Strobe, one cycle per reference frame |
| pair_o | output | NCH*2*SW | Sample pair per channel, low half is the earlier sample |

## Verification
The bench first holds every channel in phase with the reference. This shows that the run count reaches its limit and that the pairs follow the reference framing. It then shifts one channel by one sample with correction off and then on. This separates the unshifted (S[t-1],S[t]) pair from the re-formed (S[t],S[t+1]) pair, and shows that the per-channel and global flags drop. Random phase hops, random correction enables and occasional clears follow. They exercise run restarts after short agreement, marks that are set and then removed, and clears that arrive in the middle of a frame. Every cycle is compared against a cycle model that the bench builds from the requirements.

// File: rtl/frame_align_pkg.sv
package frame_align_pkg;
  localparam int unsigned CH_DEF    = 4;
  localparam int unsigned SW_DEF    = 12;
  localparam int unsigned MATCH_DEF = 8;
endpackage

// File: rtl/frame_edge.sv
module frame_edge #(
  parameter int unsigned SW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          fclk_i,
  input  logic [SW-1:0] samp_i,
  output logic          start_o,
  output logic          start_q_o,
  output logic          tog_o,
  output logic [SW-1:0] samp_q_o
);
  logic fclk_q;

  assign start_o = fclk_i & ~fclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fclk_q    <= 1'b0;
      start_q_o <= 1'b0;
      tog_o     <= 1'b0;
      samp_q_o  <= '0;
    end else if (clr_i) begin
      fclk_q    <= 1'b0;
      start_q_o <= 1'b0;
      tog_o     <= 1'b0;
      samp_q_o  <= '0;
    end else begin
      fclk_q    <= fclk_i;
      start_q_o <= start_o;
      samp_q_o  <= samp_i;
      if (start_o) tog_o <= ~tog_o;
    end
  end

  AST_TOGGLE_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && !clr_i) |=> (tog_o != $past(tog_o))); // R1
endmodule

// File: rtl/align_track.sv
module align_track #(
  parameter int unsigned MATCH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic ref_start_i,
  input  logic ref_start_q_i,
  input  logic ch_start_i,
  output logic aligned_o,
  output logic offset_o
);
  localparam int unsigned CW = $clog2(MATCH + 1);
  logic [CW-1:0] cnt_q;

  assign aligned_o = (cnt_q == CW'(MATCH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      offset_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q    <= '0;
      offset_o <= 1'b0;
    end else begin
      if (ref_start_i ^ ch_start_i) cnt_q <= '0;
      else if (ref_start_i && !aligned_o) cnt_q <= cnt_q + 1'b1;
      // one cycle late against reference => one-sample pairing offset
      if (ch_start_i && ref_start_i) offset_o <= 1'b0;
      else if (ch_start_i && ref_start_q_i) offset_o <= 1'b1;
    end
  end

  AST_MISMATCH_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && (ref_start_i ^ ch_start_i)) |=> !aligned_o); // R3
  AST_CLR_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!aligned_o && !offset_o)); // R7
endmodule

// File: rtl/pair_builder.sv
module pair_builder #(
  parameter int unsigned SW = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [SW-1:0]   samp_i,
  input  logic [SW-1:0]   samp_q_i,
  input  logic            own_sec_i,
  input  logic            ref_sec_i,
  input  logic            upd_i,
  input  logic            sel_i,
  output logic [2*SW-1:0] pair_o
);
  logic [2*SW-1:0] own_q, ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q  <= '0;
      ref_q  <= '0;
      pair_o <= '0;
    end else if (clr_i) begin
      own_q  <= '0;
      ref_q  <= '0;
      pair_o <= '0;
    end else begin
      if (own_sec_i) own_q <= {samp_i, samp_q_i};
      if (ref_sec_i) ref_q <= {samp_i, samp_q_i};
      if (upd_i) pair_o <= sel_i ? ref_q : own_q;
    end
  end
endmodule

// File: rtl/frame_align_top.sv
module frame_align_top
  import frame_align_pkg::*;
#(
  parameter int unsigned NCH   = CH_DEF,
  parameter int unsigned SW    = SW_DEF,
  parameter int unsigned MATCH = MATCH_DEF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  realign_en_i,
  input  logic [NCH-1:0]        fclk_i,
  input  logic [NCH*SW-1:0]     sample_i,
  output logic [NCH-1:0]        toggle_o,
  output logic [NCH-1:0]        ch_aligned_o,
  output logic                  all_aligned_o,
  output logic                  pair_vld_o,
  output logic [NCH*2*SW-1:0]   pair_o
);
  localparam int unsigned PW = 2 * SW;

  logic [NCH-1:0] start, start_q, offset;
  logic [SW-1:0]  samp_q [NCH];
  logic           ref_q2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q2     <= 1'b0;
      pair_vld_o <= 1'b0;
    end else if (clr_i) begin
      ref_q2     <= 1'b0;
      pair_vld_o <= 1'b0;
    end else begin
      ref_q2     <= start_q[0];
      pair_vld_o <= ref_q2;
    end
  end

  assign all_aligned_o = &ch_aligned_o;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    frame_edge #(.SW(SW)) u_edge (
      .clk_i, .rst_ni, .clr_i,
      .fclk_i   (fclk_i[c]),
      .samp_i   (sample_i[c*SW +: SW]),
      .start_o  (start[c]),
      .start_q_o(start_q[c]),
      .tog_o    (toggle_o[c]),
      .samp_q_o (samp_q[c])
    );

    pair_builder #(.SW(SW)) u_pair (
      .clk_i, .rst_ni, .clr_i,
      .samp_i   (sample_i[c*SW +: SW]),
      .samp_q_i (samp_q[c]),
      .own_sec_i(start_q[c]),
      .ref_sec_i(start_q[0]),
      .upd_i    (ref_q2),
      .sel_i    (realign_en_i & offset[c]),
      .pair_o   (pair_o[c*PW +: PW])
    );

    if (c == 0) begin : g_ref
      assign offset[c]       = 1'b0;
      assign ch_aligned_o[c] = 1'b1;
    end else begin : g_trk
      align_track #(.MATCH(MATCH)) u_trk (
        .clk_i, .rst_ni, .clr_i,
        .ref_start_i  (start[0]),
        .ref_start_q_i(start_q[0]),
        .ch_start_i   (start[c]),
        .aligned_o    (ch_aligned_o[c]),
        .offset_o     (offset[c])
      );
      AST_ALL_FALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ch_aligned_o[c]) |-> !all_aligned_o); // R4
    end
  end

  AST_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_vld_o |=> !pair_vld_o); // R5
  AST_PAIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pair_vld_o && !$past(clr_i)) |-> $stable(pair_o)); // R8
  AST_CLR_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (toggle_o == '0 && !pair_vld_o)); // R7
endmodule

// File: tb/tb_frame_align_top.sv
`timescale 1ns/1ps
module tb_frame_align_top;
  localparam int NCH = 4, SW = 12, MATCH = 8, PW = 2 * SW;

  logic clk = 0, rst_ni = 0, clr = 0, en = 0;
  logic [NCH-1:0] fclk = '0;
  logic [NCH*SW-1:0] smp = '0;
  logic [NCH-1:0] tog_o, al_o;
  logic all_o, vld_o;
  logic [NCH*PW-1:0] pair_o, pair_prev;

  int checks = 0, fails = 0, cyc = 0, wd = 0;
  int phase [NCH];

  // model state
  logic m_fq [NCH], m_tog [NCH], m_stq [NCH], m_off [NCH];
  int   m_cnt [NCH];
  logic [SW-1:0] m_sq [NCH];
  logic [PW-1:0] m_own [NCH], m_ref [NCH], m_pair [NCH];
  logic m_rq2, m_vld;

  frame_align_top #(.NCH(NCH), .SW(SW), .MATCH(MATCH)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr), .realign_en_i(en),
    .fclk_i(fclk), .sample_i(smp), .toggle_o(tog_o), .ch_aligned_o(al_o),
    .all_aligned_o(all_o), .pair_vld_o(vld_o), .pair_o(pair_o));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", wd);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic exp_aligned(input int c);
    return (c == 0) ? 1'b1 : (m_cnt[c] == MATCH);
  endfunction

  task automatic model_clear();
    for (int c = 0; c < NCH; c++) begin
      m_fq[c] = 0; m_tog[c] = 0; m_stq[c] = 0; m_off[c] = 0; m_cnt[c] = 0;
      m_sq[c] = '0; m_own[c] = '0; m_ref[c] = '0; m_pair[c] = '0;
    end
    m_rq2 = 0; m_vld = 0;
  endtask

  // advance the requirement model one cycle with the applied inputs
  task automatic model_step();
    logic st [NCH];
    logic old_stq [NCH], old_off [NCH];
    logic [SW-1:0] old_sq [NCH];
    logic [PW-1:0] old_own [NCH], old_ref [NCH];
    logic old_rq2;
    if (clr) begin model_clear(); return; end
    for (int c = 0; c < NCH; c++) begin
      st[c] = fclk[c] & ~m_fq[c];
      old_stq[c] = m_stq[c]; old_off[c] = m_off[c]; old_sq[c] = m_sq[c];
      old_own[c] = m_own[c]; old_ref[c] = m_ref[c];
    end
    old_rq2 = m_rq2;
    for (int c = 0; c < NCH; c++) begin
      logic [SW-1:0] s;
      s = smp[c*SW +: SW];
      m_fq[c] = fclk[c];
      if (st[c]) m_tog[c] = ~m_tog[c];
      m_sq[c] = s;
      m_stq[c] = st[c];
      if (c > 0) begin
        if (st[0] ^ st[c]) m_cnt[c] = 0;
        else if (st[0] && m_cnt[c] < MATCH) m_cnt[c]++;
        if (st[c] && st[0]) m_off[c] = 0;
        else if (st[c] && old_stq[0]) m_off[c] = 1;
      end
      if (old_stq[c]) m_own[c] = {s, old_sq[c]};
      if (old_stq[0]) m_ref[c] = {s, old_sq[c]};
      if (old_rq2) m_pair[c] = (en && old_off[c]) ? old_ref[c] : old_own[c];
    end
    m_rq2 = old_stq[0];
    m_vld = old_rq2;
  endtask

  task automatic compare();
    logic all_e;
    all_e = 1;
    for (int c = 0; c < NCH; c++) begin
      chk("R1 toggle", tog_o[c], m_tog[c]);
      chk("R2 ch_aligned", al_o[c], exp_aligned(c));
      all_e &= exp_aligned(c);
    end
    chk("R4 all_aligned", all_o, all_e);
    chk("R5 pair_vld", vld_o, m_vld);
    for (int c = 0; c < NCH; c++)
      chk((c > 0 && m_off[c] && en) ? "R6 corrected pair" : "R5 pair",
          pair_o[c*PW +: PW], m_pair[c]);
    if (!vld_o && !clr) chk("R8 pair hold", pair_o, pair_prev);
  endtask

  task automatic step(input logic c_clr, input logic c_en);
    logic was_clr;
    clr = c_clr; en = c_en; was_clr = c_clr;
    for (int c = 0; c < NCH; c++) begin
      fclk[c] = (((cyc + phase[c]) & 1) == 0);
      smp[c*SW +: SW] = SW'($urandom);
    end
    model_step();
    pair_prev = pair_o;
    @(posedge clk);
    @(negedge clk);
    cyc++;
    clr = 0;
    if (was_clr) begin
      chk("R7 clear toggles", tog_o, '0);
      chk("R7 clear pairs", pair_o, '0);
      chk("R7 clear all_aligned", all_o, 1'b0);
      pair_prev = pair_o;
    end else compare();
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    model_clear();
    for (int c = 0; c < NCH; c++) phase[c] = 0;
    pair_prev = '0;
    repeat (3) @(negedge clk);
    chk("R7 reset toggles", tog_o, '0);
    chk("R7 reset vld", vld_o, 1'b0);
    chk("R7 reset all_aligned", all_o, 1'b0);
    rst_ni = 1;
    pair_prev = pair_o;

    // directed: all in phase
    repeat (24) step(0, 0);
    chk("R2 all aligned after run", all_o, 1'b1);

    // directed: channel 2 one sample late, no correction
    phase[2] = 1;
    repeat (4) step(0, 0);
    chk("R3 ch2 dropped", al_o[2], 1'b0);
    chk("R4 global dropped", all_o, 1'b0);
    repeat (20) step(0, 0);
    // with correction
    repeat (20) step(0, 1);

    // directed clear mid-frame
    step(1, 1);
    phase[2] = 0;
    repeat (24) step(0, 1);

    // random segments
    for (int seg = 0; seg < 60; seg++) begin
      logic e;
      e = 1'($urandom);
      for (int c = 1; c < NCH; c++)
        if (($urandom % 4) == 0) phase[c] = 1 - phase[c];
      if (($urandom % 8) == 0) phase[0] = 1 - phase[0];
      for (int k = 0; k < 40; k++)
        step((($urandom % 300) == 0), e);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule